// File: doc/BRIEF.md
# Timer Interrupt Flag and Mask Register Pair

This block holds the event flags of a timer and the mask that selects which of them may interrupt the processor. The timer core reports six kinds of event as one-cycle pulses: underflow, overflow and four compare matches, named A to D. Each pulse sets a sticky flag. Software reads and writes the flags and the mask over a small synchronous register bus.

A flag is cleared by writing 0 to its bit. The write counts only if software has read the flag as 1 since the last write to the status register. A read arms each flag that it returns as 1. Any status write disarms every flag. As a result, a flag that rises after software sampled the register survives a write of 0 that was meant for the earlier state, and the event is not lost.

The mask register enables the overflow and compare flags one by one. The enabled flags are ORed into a single registered interrupt request. The underflow flag has no mask bit and never raises the request.

Top module: `timer_irq_flags`

## Requirements
- R1: After reset all flags, arm bits and mask bits are 0. Reads of either register return 0x00, and `irq` is 0.
- R2: A read strobe at address 0 returns the status register on `rdata` in the next cycle. Bit 5 is underflow, bit 4 is overflow, bits 3..0 are compare D, C, B, A, and bits 7..6 read 0. `rdata` holds its value between reads.
- R3: Address 1 is the mask register. Bit 4 enables overflow and bits 3..0 enable compare D..A. Bits 7..5 are not stored and read 0.
- R4: An event pulse sets its flag at the next clock edge. The flag stays 1 until it is cleared.
- R5: Writing 1 to a status bit leaves that flag unchanged.
- R6: Writing 0 to a status bit clears the flag if the last status read returned 1 for it and no status write has happened since.
- R7: A flag that was read as 0 and set afterwards stays 1 when 0 is written to its bit.
- R8: Any status write disarms every flag. A second write of 0 with no read in between leaves the flags unchanged.
- R9: One status write clears every armed flag whose bit is written 0.
- R10: If an event pulse and a valid clear reach the same flag in the same cycle, the flag stays 1.
- R11: `irq` is registered. In each cycle it equals the OR, over the previous cycle, of each overflow or compare flag ANDed with its mask bit. Underflow never contributes.
- R12: Reads of addresses 2 and 3 return 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Register address: 0 status, 1 mask |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after `rd_en` |
| evt_udf | input | 1 | Underflow event pulse |
| evt_ovf | input | 1 | Overflow event pulse |
| evt_cmp | input | 4 | Compare-match pulses, bit 0 = A … bit 3 = D |
| irq | output | 1 | Registered interrupt request |

## Verification
A wrong arm bit shows up as a flag that survives, or vanishes after, a write of 0. The next status read exposes it, so it is visible within two cycles of the write. A lost or extra flag, or a wrong mask bit, appears on `irq` one cycle after the state goes wrong, and in the following status or mask read. Random reads and writes are checked every cycle against a model built from the requirements. Directed sequences add the three-step read, event, write order and the case where an event and a clear arrive together.

// File: rtl/timer_irq_flags.sv
module timer_irq_flags #(
  parameter int ADDR_W   = 2,
  parameter int N_CMP    = 4,
  parameter int STS_ADDR = 0,
  parameter int ENA_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              evt_udf,
  input  logic              evt_ovf,
  input  logic [N_CMP-1:0]  evt_cmp,
  output logic              irq
);
  localparam int NF = N_CMP + 2;
  localparam int NE = N_CMP + 1;
  localparam logic [ADDR_W-1:0] STS_A = STS_ADDR[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] ENA_A = ENA_ADDR[ADDR_W-1:0];

  logic [NF-1:0] flags, arm, evt;
  logic [NE-1:0] en;
  logic          sts_wr, sts_rd, ena_wr;

  assign evt    = {evt_udf, evt_ovf, evt_cmp};
  assign sts_wr = wr_en && addr == STS_A;
  assign sts_rd = rd_en && addr == STS_A;
  assign ena_wr = wr_en && addr == ENA_A;

  for (genvar i = 0; i < NF; i++) begin : g_flag
    logic clr;
    assign clr = sts_wr && arm[i] && !wdata[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        flags[i] <= 1'b0;
        arm[i]   <= 1'b0;
      end else begin
        flags[i] <= evt[i] || (flags[i] && !clr);
        if (sts_wr)      arm[i] <= 1'b0;
        else if (sts_rd) arm[i] <= arm[i] || flags[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      en <= '0;
    else if (ena_wr) en <= wdata[NE-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_en) begin
      if (addr == STS_A)      rdata <= 8'(flags);
      else if (addr == ENA_A) rdata <= 8'(en);
      else                    rdata <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(flags[NE-1:0] & en);
  end
endmodule

// File: rtl/timer_irq_flags_chk.sv
module timer_irq_flags_chk #(
  parameter int ADDR_W   = 2,
  parameter int N_CMP    = 4,
  parameter int STS_ADDR = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              rd_en,
  input logic              wr_en,
  input logic [7:0]        wdata,
  input logic [7:0]        rdata,
  input logic              irq,
  input logic [N_CMP+1:0]  evt,
  input logic [N_CMP+1:0]  flags,
  input logic [N_CMP+1:0]  arm,
  input logic [N_CMP:0]    en
);
  localparam int NF = N_CMP + 2;
  localparam logic [ADDR_W-1:0] STS_A = STS_ADDR[ADDR_W-1:0];

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[7:NF] == '0);

  // R8
  disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == STS_A) |=> arm == '0);

  // R11
  irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq == $past(|(flags[NF-2:0] & en)));

  for (genvar i = 0; i < NF; i++) begin : g_bit
    // R4
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> flags[i]);
    // R6
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flags[i]) |-> $past(wr_en && addr == STS_A && !wdata[i] && arm[i]));
    // R7
    arm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(arm[i]) |-> $past(rd_en && addr == STS_A && flags[i]));
  end
endmodule

bind timer_irq_flags timer_irq_flags_chk #(
  .ADDR_W(ADDR_W), .N_CMP(N_CMP), .STS_ADDR(STS_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
  .wdata(wdata), .rdata(rdata), .irq(irq), .evt(evt), .flags(flags),
  .arm(arm), .en(en)
);

// File: tb/test_timer_irq_flags.sv
module test_timer_irq_flags;
  logic       clk = 0, rst_n = 0;
  logic [1:0] addr = 0;
  logic       rd_en = 0, wr_en = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic       evt_udf = 0, evt_ovf = 0;
  logic [3:0] evt_cmp = 0;
  logic       irq;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic [5:0] m_f = 0, m_a = 0;
  logic [4:0] m_e = 0;
  logic [7:0] m_rd = 0;
  logic       m_irq = 0;

  always #4 clk = ~clk;

  timer_irq_flags i_timer_irq_flags (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .evt_udf(evt_udf), .evt_ovf(evt_ovf),
    .evt_cmp(evt_cmp), .irq(irq)
  );

  function automatic logic [7:0] read_val(logic [1:0] a, logic [5:0] f, logic [4:0] e);
    if (a == 0) return {2'b00, f};
    if (a == 1) return {3'b000, e};
    return 8'h00;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one cycle: inputs driven now (negedge), model updated at the edge
  task automatic step(bit rd, bit wr, logic [1:0] a, logic [7:0] wd, logic [5:0] ev);
    logic [5:0] of, oa, clr;
    logic [4:0] oe;
    rd_en = rd; wr_en = wr; addr = a; wdata = wd;
    {evt_udf, evt_ovf, evt_cmp} = ev;
    @(posedge clk);
    of = m_f; oa = m_a; oe = m_e;
    clr = (wr && a == 0) ? (oa & ~wd[5:0]) : 6'h0;
    m_f = ev | (of & ~clr);
    if (wr && a == 0)      m_a = 0;
    else if (rd && a == 0) m_a = oa | of;
    if (wr && a == 1) m_e = wd[4:0];
    if (rd) m_rd = read_val(a, of, oe);
    m_irq = |(of[4:0] & oe);
    @(negedge clk);
    check("R11 irq", {7'b0, irq}, {7'b0, m_irq});
    check("R2 rdata", rdata, m_rd);
  endtask

  task automatic idle(); step(0, 0, 0, 0, 0); endtask
  task automatic wr(logic [1:0] a, logic [7:0] d); step(0, 1, a, d, 0); endtask
  task automatic rd_chk(logic [1:0] a, logic [7:0] exp, string tag);
    step(1, 0, a, 0, 0);
    check(tag, rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1
    check("R1 irq", {7'b0, irq}, 8'h00);
    rd_chk(0, 8'h00, "R1 status");
    rd_chk(1, 8'h00, "R1 mask");
    // R4
    step(0, 0, 0, 0, 6'h10);
    rd_chk(0, 8'h10, "R4 overflow set");
    // R5
    wr(0, 8'hFF);
    rd_chk(0, 8'h10, "R5 write one");
    // R6
    wr(0, 8'h00);
    rd_chk(0, 8'h00, "R6 cleared");
    // R7
    step(0, 0, 0, 0, 6'h01);
    wr(0, 8'h00);
    rd_chk(0, 8'h01, "R7 unread flag kept");
    // R8
    wr(0, 8'hFF);
    wr(0, 8'h00);
    rd_chk(0, 8'h01, "R8 disarmed");
    // R9
    step(0, 0, 0, 0, 6'h06);
    rd_chk(0, 8'h07, "R9 before");
    wr(0, 8'h00);
    rd_chk(0, 8'h00, "R9 multi clear");
    // R10
    step(0, 0, 0, 0, 6'h08);
    rd_chk(0, 8'h08, "R10 before");
    step(0, 1, 0, 8'h00, 6'h08);
    rd_chk(0, 8'h08, "R10 set wins");
    // R3
    wr(1, 8'hFF);
    rd_chk(1, 8'h1F, "R3 mask reserved");
    // R11
    idle();
    check("R11 enabled compare", {7'b0, irq}, 8'h01);
    rd_chk(0, 8'h08, "R11 arm");
    wr(0, 8'h00);
    step(0, 0, 0, 0, 6'h20);
    idle(); idle();
    check("R11 underflow no irq", {7'b0, irq}, 8'h00);
    step(0, 0, 0, 0, 6'h10);
    wr(1, 8'h0F);
    idle(); idle();
    check("R11 masked overflow", {7'b0, irq}, 8'h00);
    // R12
    wr(2, 8'hFF);
    wr(3, 8'h00);
    rd_chk(1, 8'h0F, "R12 mask untouched");
    rd_chk(0, 8'h30, "R12 flags untouched");
    rd_chk(3, 8'h00, "R12 unmapped read");
    // random traffic
    for (int k = 0; k < 5000; k++) begin
      int op = $urandom % 4;
      logic [5:0] ev = 6'($urandom & $urandom & $urandom);
      logic [1:0] a = ($urandom % 4 == 0) ? 2'($urandom) : 2'($urandom % 2);
      logic [7:0] d = 8'($urandom | $urandom);
      case (op)
        0: step(0, 0, 0, 0, ev);
        1: step(1, 0, a, 0, ev);
        2: step(0, 1, a, d, ev);
        default: step(1, 0, 0, 0, ev);
      endcase
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule